// File: doc/BRIEF.md
# Two-Step Conversion Strobe Sequencer

This block turns one convert command into the complete set of internal control signals for a single two-step (coarse then fine) conversion. It runs on a fast system clock and synchronises the command. It reacts only to the command's rising edge, then issues a fixed sequence at fixed clock offsets from that edge. The sequence is: the hold level, a coarse-encoder strobe, a window during which the residue amplifier is enabled, the return to tracking, a fine-encoder strobe and a result-transfer strobe. The command's pulse width has no effect.

The length of the conversion window is fixed. The tracking (sample) interval is whatever remains of the command period, so it grows or shrinks with the conversion rate. The residue amplifier is blanked (`blank_o` high) from the moment acquisition starts until the coarse result has been taken. A rising command edge that arrives while a conversion is running is discarded, and a one-cycle error pulse flags it. All offsets are parameters in nanosecond steps, scaled by a clock-ticks-per-step parameter. Elaboration rejects any set of offsets that is zero or out of order.

The controller is a state machine. **IDLE** (tracking) goes to **LEAD** on an accepted edge. **LEAD** goes to **SETTLE** (hold asserted) at the hold offset. **SETTLE** goes to **COARSE** (one-cycle strobe), then to **RESID** (hold, amplifier active), then to **RETRACK** (hold released, blanked again) at the end of the fixed window. **RETRACK** goes to **FINE** (one-cycle strobe), then to **GAP**, then to **XFER** (one-cycle strobe), and back to **IDLE**. When the chosen offsets leave no cycles for LEAD, RESID or GAP, that state is skipped.

Top module: `subrange_seq`

## Requirements
Cycle numbering: a command edge is "recognised" in cycle s, which is SYNC_STAGES clock edges after the first edge that samples `cmd_in` high. Offset d means cycle s+d. The defaults are SYNC_STAGES=2, ticks-per-step 1, hold 6, coarse +65, window 135, fine +85, transfer +4. These defaults give absolute offsets of 6, 71, 141, 156 and 160.
- R1: While reset is active, and after reset until a command edge arrives, `hold_o`=0, `blank_o`=1, and all three strobes and `overlap_err_o` are 0.
- R2: Only a rising edge of `cmd_in` starts a conversion. A one-clock pulse and a level held high for longer than the whole conversion produce the same output sequence, and the level does not start a second conversion.
- R3: `hold_o` is 1 from offset 6 through offset 140, which is exactly the 135-cycle window, and 0 elsewhere.
- R4: `coarse_strb_o` is high for exactly one cycle, at offset 71. `hold_o` and `blank_o` are both 1 in that cycle.
- R5: `blank_o` is 0 only from offset 72 through offset 140, the cycles after the coarse strobe until hold ends. It is 1 in every other cycle, including all of idle tracking.
- R6: `fine_strb_o` is high for exactly one cycle, at offset 156, with `hold_o`=0.
- R7: `xfer_strb_o` is high for exactly one cycle, at offset 160. The next cycle is idle, and an edge recognised there (offset 161) starts a new conversion.
- R8: Between conversions `hold_o` stays 0 for as long as no edge arrives. The next conversion's timing is set only by its own edge, so the tracking time follows the command period.
- R9: An edge recognised at any offset from 1 through 160 is ignored. `overlap_err_o` is 1 in that cycle only, the running sequence is unchanged, and no further conversion follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_in | input | 1 | Convert command, rising-edge active |
| hold_o | output | 1 | 1 = hold, 0 = track |
| blank_o | output | 1 | 1 = residue amplifier input blanked |
| coarse_strb_o | output | 1 | One-cycle coarse encoder strobe |
| fine_strb_o | output | 1 | One-cycle fine encoder strobe |
| xfer_strb_o | output | 1 | One-cycle result register transfer strobe |
| overlap_err_o | output | 1 | One-cycle pulse: command edge ignored while busy |

## Verification
The transfer strobe and the rejection of a new edge can land in the same cycle. This happens when an edge is recognised exactly at offset 160, the last busy cycle. The bench provokes it by timing a second command pulse to that cycle. It then expects `xfer_strb_o` and `overlap_err_o` high together and no hold for the next 200 cycles. A companion case places the edge one cycle later and expects a full new sequence starting at offset 161. Together the two cases pin down the exact boundary between busy and idle.

// File: rtl/subrange_seq_pkg.sv
package subrange_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_LEAD,
        ST_SETTLE,
        ST_COARSE,
        ST_RESID,
        ST_RETRACK,
        ST_FINE,
        ST_GAP,
        ST_XFER
    } seq_state_e;

    // Maps a cycle count since the accepted edge onto its phase.
    function automatic seq_state_e phase_of(
        input int unsigned c,
        input int unsigned t_hold,
        input int unsigned t_coarse,
        input int unsigned t_rel,
        input int unsigned t_fine,
        input int unsigned t_xfer
    );
        seq_state_e p;
        if (c < t_hold)         p = ST_LEAD;
        else if (c < t_coarse)  p = ST_SETTLE;
        else if (c == t_coarse) p = ST_COARSE;
        else if (c < t_rel)     p = ST_RESID;
        else if (c < t_fine)    p = ST_RETRACK;
        else if (c == t_fine)   p = ST_FINE;
        else if (c < t_xfer)    p = ST_GAP;
        else                    p = ST_XFER;
        return p;
    endfunction

endpackage

// File: rtl/subrange_seq_sync.sv
module subrange_seq_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[0] <= 1'b0;
                else        chain[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[i] <= 1'b0;
                else        chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/subrange_seq_edge.sv
module subrange_seq_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise
);
    logic prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= lvl;
    end

    assign rise = lvl & ~prev;
endmodule

// File: rtl/subrange_seq_ctr.sv
module subrange_seq_ctr #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         adv,
    output logic [W-1:0] cnt,
    output logic [W-1:0] cnt_nx
);
    always_comb begin
        if (start)    cnt_nx = W'(1);
        else if (adv) cnt_nx = cnt + W'(1);
        else          cnt_nx = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt_nx;
    end
endmodule

// File: rtl/subrange_seq.sv
module subrange_seq
    import subrange_seq_pkg::*;
#(
    parameter int unsigned SYNC_STAGES  = 2,
    parameter int unsigned TICKS_PER_NS = 1,
    parameter int unsigned HOLD_NS      = 6,
    parameter int unsigned COARSE_NS    = 65,
    parameter int unsigned WINDOW_NS    = 135,
    parameter int unsigned FINE_NS      = 85,
    parameter int unsigned XFER_NS      = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_in,
    output logic hold_o,
    output logic blank_o,
    output logic coarse_strb_o,
    output logic fine_strb_o,
    output logic xfer_strb_o,
    output logic overlap_err_o
);
    // Absolute offsets, in clocks, from the accepted edge.
    localparam int unsigned T_HOLD   = HOLD_NS * TICKS_PER_NS;
    localparam int unsigned T_COARSE = T_HOLD + COARSE_NS * TICKS_PER_NS;
    localparam int unsigned T_REL    = T_HOLD + WINDOW_NS * TICKS_PER_NS;
    localparam int unsigned T_FINE   = T_COARSE + FINE_NS * TICKS_PER_NS;
    localparam int unsigned T_XFER   = T_FINE + XFER_NS * TICKS_PER_NS;
    localparam int unsigned CNT_W    = $clog2(T_XFER + 2);

    if (SYNC_STAGES == 0 || T_HOLD == 0 || !(T_HOLD < T_COARSE) ||
        !(T_COARSE < T_REL) || !(T_REL < T_FINE) || !(T_FINE < T_XFER)) begin : g_bad_timing
        $error("subrange_seq: offsets must be nonzero and strictly increasing");
    end

    logic             cmd_s;
    logic             rise;
    logic             start;
    logic             adv;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_nx;
    seq_state_e       state;
    seq_state_e       state_nx;

    subrange_seq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (cmd_in),
        .q     (cmd_s)
    );

    subrange_seq_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (cmd_s),
        .rise  (rise)
    );

    assign start = rise && (state == ST_IDLE);
    assign adv   = (state != ST_IDLE) && (state != ST_XFER);

    subrange_seq_ctr #(.W(CNT_W)) u_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .adv    (adv),
        .cnt    (cnt),
        .cnt_nx (cnt_nx)
    );

    // Next-state selection.
    always_comb begin
        unique case (state)
            ST_IDLE: state_nx = start ? phase_of(32'(cnt_nx), T_HOLD, T_COARSE, T_REL, T_FINE, T_XFER)
                                      : ST_IDLE;
            ST_XFER: state_nx = ST_IDLE;
            default: state_nx = phase_of(32'(cnt_nx), T_HOLD, T_COARSE, T_REL, T_FINE, T_XFER);
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Outputs decoded from the state.
    always_comb begin
        hold_o        = 1'b0;
        blank_o       = 1'b1;
        coarse_strb_o = 1'b0;
        fine_strb_o   = 1'b0;
        xfer_strb_o   = 1'b0;
        unique case (state)
            ST_IDLE, ST_LEAD, ST_RETRACK, ST_GAP: ;
            ST_SETTLE:  hold_o = 1'b1;
            ST_COARSE: begin
                hold_o        = 1'b1;
                coarse_strb_o = 1'b1;
            end
            ST_RESID: begin
                hold_o  = 1'b1;
                blank_o = 1'b0;
            end
            ST_FINE:    fine_strb_o = 1'b1;
            ST_XFER:    xfer_strb_o = 1'b1;
            default: ;
        endcase
        overlap_err_o = rise && (state != ST_IDLE);
    end

endmodule

// File: rtl/subrange_seq_chk.sv
module subrange_seq_chk #(
    parameter int unsigned D_HOLD   = 6,
    parameter int unsigned D_COARSE = 71,
    parameter int unsigned D_REL    = 141,
    parameter int unsigned D_FINE   = 156,
    parameter int unsigned D_XFER   = 160
) (
    input logic clk,
    input logic rst_n,
    input logic hold,
    input logic blank,
    input logic coarse,
    input logic fine,
    input logic xfer
);
    logic        hold_q;
    logic [15:0] since_hold;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q     <= 1'b0;
            since_hold <= '0;
        end else begin
            hold_q <= hold;
            if (hold && !hold_q)        since_hold <= 16'd1;
            else if (since_hold != '1)  since_hold <= since_hold + 16'd1;
        end
    end

    p_one_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({coarse, fine, xfer}));
    p_coarse_in_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        coarse |-> (hold && blank));
    p_coarse_delay_r4: assert property (@(posedge clk) disable iff (!rst_n)
        coarse |-> (since_hold == 16'(D_COARSE - D_HOLD)));
    p_hold_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold) |-> (since_hold == 16'(D_REL - D_HOLD)));
    p_blank_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(blank) |-> $past(coarse));
    p_blank_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(blank) |-> $fell(hold));
    p_fine_track_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fine |-> (!hold && blank && since_hold == 16'(D_FINE - D_HOLD)));
    p_xfer_delay_r7: assert property (@(posedge clk) disable iff (!rst_n)
        xfer |-> (since_hold == 16'(D_XFER - D_HOLD)));
endmodule

bind subrange_seq subrange_seq_chk #(
    .D_HOLD   (T_HOLD),
    .D_COARSE (T_COARSE),
    .D_REL    (T_REL),
    .D_FINE   (T_FINE),
    .D_XFER   (T_XFER)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .hold   (hold_o),
    .blank  (blank_o),
    .coarse (coarse_strb_o),
    .fine   (fine_strb_o),
    .xfer   (xfer_strb_o)
);

// File: tb/subrange_seq_bench.sv
module subrange_seq_bench;
    localparam int SYNC     = 2;
    localparam int D_HOLD   = 6;
    localparam int D_COARSE = 71;
    localparam int D_REL    = 141;
    localparam int D_FINE   = 156;
    localparam int D_XFER   = 160;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd = 1'b0;
    logic hold, blank, coarse, fine, xfer, err;
    int   cyc = 0;
    int   n_run = 0;
    int   n_fail = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    subrange_seq u_subrange_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .cmd_in        (cmd),
        .hold_o        (hold),
        .blank_o       (blank),
        .coarse_strb_o (coarse),
        .fine_strb_o   (fine),
        .xfer_strb_o   (xfer),
        .overlap_err_o (err)
    );

    task automatic chk(bit ok, string what, int at, int act, int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", what, at, act, exp);
        end
    endtask

    // Expected {hold, blank, coarse, fine, xfer} for offset d from recognition.
    function automatic logic [4:0] model(int i, int s1, int s2);
        int s;
        int d;
        s = -1;
        if (s1 >= 0 && i >= s1) s = s1;
        if (s2 >= 0 && i >= s2) s = s2;
        if (s < 0) return 5'b01000;
        d = i - s;
        return {(d >= D_HOLD && d < D_REL),
                !(d > D_COARSE && d < D_REL),
                (d == D_COARSE), (d == D_FINE), (d == D_XFER)};
    endfunction

    task automatic check_window(string tag, int from, int to, int s1, int s2, int e1);
        logic [5:0] ex, ac;
        int         bad_at [6];
        int         bad_ac [6];
        int         bad_ex [6];
        string      nm [6];
        nm[0] = "R3 hold"; nm[1] = "R5 blank"; nm[2] = "R4 coarse";
        nm[3] = "R6 fine"; nm[4] = "R7 xfer";  nm[5] = "R9 overlap_err";
        for (int k = 0; k < 6; k++) bad_at[k] = -1;
        @(negedge clk);
        while (cyc < from) @(negedge clk);
        while (cyc <= to) begin
            ex = {model(cyc, s1, s2), (cyc == e1)};
            ac = {hold, blank, coarse, fine, xfer, err};
            for (int k = 0; k < 6; k++) begin
                if (ac[5-k] !== ex[5-k] && bad_at[k] < 0) begin
                    bad_at[k] = cyc;
                    bad_ac[k] = int'(ac[5-k]);
                    bad_ex[k] = int'(ex[5-k]);
                end
            end
            @(negedge clk);
        end
        for (int k = 0; k < 6; k++)
            chk(bad_at[k] < 0, {nm[k], " / ", tag}, bad_at[k], bad_ac[k], bad_ex[k]);
    endtask

    task automatic drive(int at, int width);
        @(negedge clk);
        while (cyc < at) @(negedge clk);
        cmd = 1'b1;
        repeat (width) @(negedge clk);
        cmd = 1'b0;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk({hold, blank, coarse, fine, xfer, err} == 6'b010000, "R1 outputs in reset",
            cyc, int'({hold, blank, coarse, fine, xfer, err}), 16);
        rst_n = 1'b1;
        check_window("R1 after reset", cyc + 1, cyc + 20, -1, -1, -1);
    endtask

    task automatic t_short_pulse;
        int a = cyc + 2;
        fork
            drive(a, 1);
            check_window("R2 one-clock pulse", a, a + SYNC + D_XFER + 10, a + SYNC, -1, -1);
        join
    endtask

    task automatic t_long_level;
        int a = cyc + 2;
        fork
            drive(a, 200);
            check_window("R2 long level", a, a + 230, a + SYNC, -1, -1);
        join
    endtask

    task automatic t_mid_overlap;
        int a = cyc + 2;
        fork
            begin drive(a, 1); drive(a + 50, 3); end
            check_window("R9 edge mid-window", a, a + SYNC + D_XFER + 100, a + SYNC, -1, a + SYNC + 50);
        join
    endtask

    task automatic t_xfer_clash;
        int a = cyc + 2;
        fork
            begin drive(a, 1); drive(a + D_XFER, 1); end
            check_window("R9 edge on xfer cycle", a, a + SYNC + D_XFER + 200, a + SYNC, -1,
                         a + SYNC + D_XFER);
        join
    endtask

    task automatic t_back_to_back;
        int a = cyc + 2;
        fork
            begin drive(a, 1); drive(a + D_XFER + 1, 1); end
            check_window("R7 back-to-back", a, a + SYNC + 2 * D_XFER + 20, a + SYNC,
                         a + SYNC + D_XFER + 1, -1);
        join
    endtask

    task automatic t_slow_rate;
        int a = cyc + 2;
        fork
            begin drive(a, 1); drive(a + 400, 5); end
            check_window("R8 stretched track", a, a + 600, a + SYNC, a + 400 + SYNC, -1);
        join
    endtask

    initial begin
        #(20 * 150000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired at cycle %0d: actual 0 expected 1", cyc);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_short_pulse();
        t_long_level();
        t_mid_overlap();
        t_xfer_clash();
        t_back_to_back();
        t_slow_rate();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule